// File: doc/BRIEF.md
# Sleep and Idle Power-Mode Controller

This block sequences a small processor subsystem through three power states: Run, Idle and Sleep. Software issues a single-cycle power-save command whose operand chooses the target state. Idle stops only the CPU clock, so peripherals keep working. Sleep stops the system clock source. That gates the CPU, the clocked peripherals, the main oscillator and the clock-failure monitor. A low-power RC oscillator stays on in Sleep only when the watchdog needs it. Peripherals that run from an external clock, and the input-change detector, stay enabled in every state.

The block leaves either low-power state when an interrupt request arrives on a line whose individual enable is set, when the watchdog times out, or on reset. It brings the subsystem back to Run on the next clock edge. A wake condition that is already present when a command arrives cancels that command. When the watchdog is enabled, the block pulses a watchdog-clear strobe on the cycle it accepts a Sleep command. The selected system clock source is held while the subsystem is low-powered, so after a wake it is the same source that was active at entry.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `mode` is Sleep (2'b10), `cpu_clk_en`, `per_clk_en` and `osc_en` are all low.
- R2: While `mode` is Idle (2'b01), `cpu_clk_en` is low, and `per_clk_en` and `osc_en` are high.
- R3: The wake condition is true if any bit of `irq_req & irq_en` is set, or if `wdt_timeout` is high. A request on a line whose enable bit is 0 does not wake the block.
- R4: If the wake condition is true while `mode` is Idle or Sleep, then on the next clock edge `mode` becomes Run (2'b00) and `cpu_clk_en` is high.
- R5: `wdt_clr` is high exactly in a cycle where all of these hold: `mode` is Run, `cmd_valid` is high, `cmd_sleep` is 1 (Sleep operand), `wdt_en` is high and there is no wake condition. It is never high for an Idle command.
- R6: `lprc_en` equals `wdt_en` while `mode` is Sleep, and is high in Run and Idle.
- R7: `clkmon_en` is low while `mode` is Sleep and high in Run and Idle.
- R8: `clk_sel` loads `clk_sel_in` on every edge taken in Run. Changes on `clk_sel_in` during Idle or Sleep have no effect, so after a wake `clk_sel` equals the value loaded on the entry edge.
- R9: `ext_per_en` is high in Run, Idle and Sleep.
- R10: On a clock edge with `rst` high, the block goes to Run. All clock enables are then high, both wake flags are low and `clk_sel` takes the value `SEL_RST`.
- R11: A command accepted in Run moves `mode` to Sleep (`cmd_sleep`=1) or to Idle (`cmd_sleep`=0) on the next edge. A command that arrives together with a wake condition leaves the block in Run. A command that arrives in Idle or Sleep is ignored.
- R12: `mode` encodes Run as 2'b00, Idle as 2'b01 and Sleep as 2'b10. `woke_sleep` (or `woke_idle`) is high for exactly the one cycle after a wake-induced move from Sleep (or from Idle) to Run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle power-save command |
| cmd_sleep | input | 1 | Command operand: 1 selects Sleep, 0 selects Idle |
| irq_req | input | N_IRQ | Interrupt request lines |
| irq_en | input | N_IRQ | Per-line interrupt enables |
| wdt_en | input | 1 | Watchdog enabled |
| wdt_timeout | input | 1 | Watchdog time-out event |
| clk_sel_in | input | SEL_W | Requested system clock source |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Enable for peripherals that use the system clock |
| osc_en | output | 1 | Main oscillator enable |
| lprc_en | output | 1 | Low-power RC oscillator enable |
| clkmon_en | output | 1 | Clock-failure monitor enable |
| ext_per_en | output | 1 | Enable for external-clock peripherals and change detection |
| wdt_clr | output | 1 | Watchdog-clear strobe on Sleep entry |
| clk_sel | output | SEL_W | Held system clock source select |
| mode | output | 2 | Current power state |
| woke_sleep | output | 1 | One-cycle flag: woke from Sleep |
| woke_idle | output | 1 | One-cycle flag: woke from Idle |

## Verification
The bench aims at these cases: a command and a wake condition arriving in the same cycle, interrupts that are requested but masked, and Sleep entry with the watchdog both enabled and disabled. Each is checked against its expected result. A design that ignores a pending wake would fall asleep and stay there. A design that skips the interrupt mask would wake on a masked line. A design that gets the watchdog cases wrong would either clear the watchdog on Idle commands or shut the RC oscillator off under a running watchdog. The bench also changes `clk_sel_in` during low-power states and applies reset from inside Sleep. A select register that keeps loading in those states would come back to Run with the wrong clock source, and a reset path that misses Sleep would leave the enables low.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [1:0] {
        PM_RUN   = 2'b00,
        PM_IDLE  = 2'b01,
        PM_SLEEP = 2'b10
    } pm_state_e;

    typedef struct packed {
        logic cpu;
        logic per;
        logic osc;
        logic lprc;
        logic mon;
        logic ext;
    } clk_en_t;

    function automatic clk_en_t decode_enables(pm_state_e st, logic wdt_on);
        clk_en_t e;
        e.cpu  = (st == PM_RUN);
        e.per  = (st != PM_SLEEP);
        e.osc  = (st != PM_SLEEP);
        e.lprc = (st != PM_SLEEP) || wdt_on;
        e.mon  = (st != PM_SLEEP);
        e.ext  = 1'b1;
        return e;
    endfunction

    function automatic pm_state_e step_state(pm_state_e cur, logic cmd,
                                             logic to_sleep, logic wake);
        pm_state_e nx;
        nx = cur;
        case (cur)
            PM_RUN:   if (cmd && !wake) nx = to_sleep ? PM_SLEEP : PM_IDLE;
            PM_IDLE,
            PM_SLEEP: if (wake) nx = PM_RUN;
            default:  nx = PM_RUN;
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
    parameter int N_IRQ = 8
) (
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             wdt_timeout,
    output logic             wake
);
    logic [N_IRQ-1:0] line_hit;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        assign line_hit[i] = irq_req[i] & irq_en[i];
    end

    assign wake = (|line_hit) | wdt_timeout;
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cmd_valid,
    input  logic      cmd_sleep,
    input  logic      wake,
    input  logic      wdt_en,
    output pm_state_e state,
    output logic      wdt_clr,
    output logic      woke_sleep,
    output logic      woke_idle
);
    pm_state_e state_nx;

    always_comb begin
        state_nx = step_state(state, cmd_valid, cmd_sleep, wake);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= PM_RUN;
            woke_sleep <= 1'b0;
            woke_idle  <= 1'b0;
        end else begin
            state      <= state_nx;
            woke_sleep <= (state == PM_SLEEP) && wake;
            woke_idle  <= (state == PM_IDLE) && wake;
        end
    end

    assign wdt_clr = (state == PM_RUN) && cmd_valid && cmd_sleep && !wake && wdt_en;
endmodule

// File: rtl/pwr_clk_ctl.sv
module pwr_clk_ctl
    import pwr_mode_pkg::*;
#(
    parameter int               SEL_W   = 3,
    parameter logic [SEL_W-1:0] SEL_RST = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  pm_state_e        state,
    input  logic             wdt_en,
    input  logic [SEL_W-1:0] clk_sel_in,
    output clk_en_t          en,
    output logic [SEL_W-1:0] clk_sel
);
    always_comb begin
        en = decode_enables(state, wdt_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_sel <= SEL_RST;
        end else if (state == PM_RUN) begin
            clk_sel <= clk_sel_in;
        end
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int               N_IRQ   = 8,
    parameter int               SEL_W   = 3,
    parameter logic [SEL_W-1:0] SEL_RST = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic             cmd_sleep,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic             wdt_en,
    input  logic             wdt_timeout,
    input  logic [SEL_W-1:0] clk_sel_in,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             osc_en,
    output logic             lprc_en,
    output logic             clkmon_en,
    output logic             ext_per_en,
    output logic             wdt_clr,
    output logic [SEL_W-1:0] clk_sel,
    output logic [1:0]       mode,
    output logic             woke_sleep,
    output logic             woke_idle
);
    logic      wake;
    pm_state_e state;
    clk_en_t   en;

    pwr_wake_detect #(.N_IRQ(N_IRQ)) u_wake (
        .irq_req     (irq_req),
        .irq_en      (irq_en),
        .wdt_timeout (wdt_timeout),
        .wake        (wake)
    );

    pwr_mode_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_sleep  (cmd_sleep),
        .wake       (wake),
        .wdt_en     (wdt_en),
        .state      (state),
        .wdt_clr    (wdt_clr),
        .woke_sleep (woke_sleep),
        .woke_idle  (woke_idle)
    );

    pwr_clk_ctl #(.SEL_W(SEL_W), .SEL_RST(SEL_RST)) u_clk (
        .clk        (clk),
        .rst        (rst),
        .state      (state),
        .wdt_en     (wdt_en),
        .clk_sel_in (clk_sel_in),
        .en         (en),
        .clk_sel    (clk_sel)
    );

    assign cpu_clk_en = en.cpu;
    assign per_clk_en = en.per;
    assign osc_en     = en.osc;
    assign lprc_en    = en.lprc;
    assign clkmon_en  = en.mon;
    assign ext_per_en = en.ext;
    assign mode       = state;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
    parameter int N_IRQ = 8,
    parameter int SEL_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic [N_IRQ-1:0] irq_req,
    input logic [N_IRQ-1:0] irq_en,
    input logic             wdt_en,
    input logic             wdt_timeout,
    input logic             cpu_clk_en,
    input logic             per_clk_en,
    input logic             osc_en,
    input logic             lprc_en,
    input logic             clkmon_en,
    input logic             wdt_clr,
    input logic [SEL_W-1:0] clk_sel,
    input logic [1:0]       mode,
    input logic             woke_sleep,
    input logic             woke_idle
);
    logic seen = 1'b0;
    always_ff @(posedge clk) seen <= 1'b1;

    logic wake_c;
    assign wake_c = (|(irq_req & irq_en)) | wdt_timeout;

    p_sleep_gated_r1: assert property (@(posedge clk) disable iff (rst)
        mode == 2'b10 |-> !cpu_clk_en && !per_clk_en && !osc_en);

    p_idle_per_on_r2: assert property (@(posedge clk) disable iff (rst)
        mode == 2'b01 |-> !cpu_clk_en && per_clk_en && osc_en);

    // R3 and R4: a wake in a low-power state returns to Run on the next edge
    p_wake_run_r4: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'b00 && wake_c) |=> (mode == 2'b00 && cpu_clk_en));

    p_wdt_clr_enter_r5: assert property (@(posedge clk) disable iff (rst)
        wdt_clr |=> mode == 2'b10);

    p_wdt_clr_cond_r5: assert property (@(posedge clk) disable iff (rst)
        wdt_clr |-> wdt_en && cmd_valid && mode == 2'b00);

    p_lprc_r6: assert property (@(posedge clk) disable iff (rst)
        mode == 2'b10 |-> lprc_en == wdt_en);

    p_mon_off_r7: assert property (@(posedge clk) disable iff (rst)
        mode == 2'b10 |-> !clkmon_en);

    p_sel_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (seen && !$past(rst) && $past(mode) != 2'b00) |-> $stable(clk_sel));

    p_reset_run_r10: assert property (@(posedge clk) disable iff (rst)
        (seen && $past(rst)) |-> (mode == 2'b00 && cpu_clk_en && per_clk_en && osc_en
                                   && lprc_en && clkmon_en && !woke_sleep && !woke_idle));

    p_cancel_r11: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 && cmd_valid && wake_c) |=> mode == 2'b00);

    p_flags_onehot_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({woke_sleep, woke_idle}));

    p_flag_sleep_r12: assert property (@(posedge clk) disable iff (rst)
        woke_sleep |-> (mode == 2'b00 && seen && $past(mode) == 2'b10));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.N_IRQ(N_IRQ), .SEL_W(SEL_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .irq_req     (irq_req),
    .irq_en      (irq_en),
    .wdt_en      (wdt_en),
    .wdt_timeout (wdt_timeout),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .osc_en      (osc_en),
    .lprc_en     (lprc_en),
    .clkmon_en   (clkmon_en),
    .wdt_clr     (wdt_clr),
    .clk_sel     (clk_sel),
    .mode        (mode),
    .woke_sleep  (woke_sleep),
    .woke_idle   (woke_idle)
);

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
    localparam int               N  = 8;
    localparam int               SW = 3;
    localparam logic [SW-1:0]    SR = 3'd5;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst, cmd_valid, cmd_sleep, wdt_en, wdt_timeout;
    logic [N-1:0]  irq_req, irq_en;
    logic [SW-1:0] clk_sel_in;
    logic          cpu_clk_en, per_clk_en, osc_en, lprc_en, clkmon_en, ext_per_en, wdt_clr;
    logic [SW-1:0] clk_sel;
    logic [1:0]    mode;
    logic          woke_sleep, woke_idle;

    pwr_mode_ctrl #(.N_IRQ(N), .SEL_W(SW), .SEL_RST(SR)) u_pwr_mode_ctrl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_sleep(cmd_sleep),
        .irq_req(irq_req), .irq_en(irq_en), .wdt_en(wdt_en), .wdt_timeout(wdt_timeout),
        .clk_sel_in(clk_sel_in), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .osc_en(osc_en), .lprc_en(lprc_en), .clkmon_en(clkmon_en), .ext_per_en(ext_per_en),
        .wdt_clr(wdt_clr), .clk_sel(clk_sel), .mode(mode),
        .woke_sleep(woke_sleep), .woke_idle(woke_idle)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // Bench model state
    logic [1:0]    m_mode = 2'b00;
    logic [SW-1:0] m_sel  = SR;
    logic          m_ws   = 1'b0;
    logic          m_wi   = 1'b0;

    function automatic logic f_wake(logic [N-1:0] q, logic [N-1:0] e, logic t);
        return ((q & e) != '0) || t;
    endfunction

    function automatic logic [1:0] f_next(logic [1:0] m, logic c, logic s, logic w);
        if (m == 2'b00) return (c && !w) ? (s ? 2'b10 : 2'b01) : 2'b00;
        return w ? 2'b00 : m;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic c, input logic s,
                        input logic [N-1:0] q, input logic [N-1:0] e,
                        input logic we, input logic wt, input logic [SW-1:0] sl);
        logic w;
        @(posedge clk);
        #1;
        rst = r; cmd_valid = c; cmd_sleep = s; irq_req = q; irq_en = e;
        wdt_en = we; wdt_timeout = wt; clk_sel_in = sl;
        #0.5;
        cyc++;
        w = f_wake(q, e, wt);
        chk("R12 mode", {6'd0, mode}, {6'd0, m_mode});
        chk("R1/R2/R4 cpu_clk_en", {7'd0, cpu_clk_en}, {7'd0, m_mode == 2'b00});
        chk("R1/R2 per_clk_en", {7'd0, per_clk_en}, {7'd0, m_mode != 2'b10});
        chk("R1 osc_en", {7'd0, osc_en}, {7'd0, m_mode != 2'b10});
        chk("R6 lprc_en", {7'd0, lprc_en}, {7'd0, (m_mode != 2'b10) || we});
        chk("R7 clkmon_en", {7'd0, clkmon_en}, {7'd0, m_mode != 2'b10});
        chk("R9 ext_per_en", {7'd0, ext_per_en}, 8'd1);
        chk("R5 wdt_clr", {7'd0, wdt_clr}, {7'd0, m_mode == 2'b00 && c && s && !w && we});
        chk("R8 clk_sel", {5'd0, clk_sel}, {5'd0, m_sel});
        chk("R12 woke flags", {6'd0, woke_sleep, woke_idle}, {6'd0, m_ws, m_wi});
        // advance the model to the next edge (R3, R4, R10, R11)
        if (r) begin
            m_mode = 2'b00; m_sel = SR; m_ws = 1'b0; m_wi = 1'b0;
        end else begin
            m_ws = (m_mode == 2'b10) && w;
            m_wi = (m_mode == 2'b01) && w;
            if (m_mode == 2'b00) m_sel = sl;
            m_mode = f_next(m_mode, c, s, w);
        end
    endtask

    task automatic summary;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'd24681));
        rst = 1'b1; cmd_valid = 0; cmd_sleep = 0; irq_req = '0; irq_en = '0;
        wdt_en = 0; wdt_timeout = 0; clk_sel_in = '0;
        // R10: reset state
        step(1, 0, 0, '0, '0, 0, 0, 3'd1);
        step(1, 0, 0, '0, '0, 0, 0, 3'd1);
        step(0, 0, 0, '0, '0, 0, 0, 3'd2);
        // R2 Idle entry, R3 masked request ignored, enabled request wakes
        step(0, 1, 0, '0, '0, 1, 0, 3'd3);
        step(0, 0, 0, 8'h10, 8'h01, 1, 0, 3'd6);
        step(0, 1, 1, '0, 8'hFF, 1, 0, 3'd7);
        step(0, 0, 0, 8'h01, 8'h01, 1, 0, 3'd7);
        step(0, 0, 0, '0, '0, 1, 0, 3'd4);
        // R5/R6 Sleep entry with watchdog on, sel change ignored (R8), watchdog wake
        step(0, 1, 1, '0, '0, 1, 0, 3'd4);
        step(0, 0, 0, '0, '0, 1, 0, 3'd0);
        step(0, 1, 0, '0, '0, 1, 0, 3'd1);
        step(0, 0, 0, '0, '0, 1, 1, 3'd2);
        step(0, 0, 0, '0, '0, 0, 0, 3'd3);
        // R5/R6 Sleep with watchdog off, irq wake
        step(0, 1, 1, '0, '0, 0, 0, 3'd6);
        step(0, 0, 0, 8'h80, 8'h7F, 0, 0, 3'd1);
        step(0, 0, 0, 8'h80, 8'h80, 0, 0, 3'd1);
        // R11: command with pending wake is cancelled
        step(0, 1, 1, 8'h04, 8'h04, 1, 0, 3'd2);
        step(0, 1, 0, '0, '0, 0, 1, 3'd2);
        // R10: reset from Sleep
        step(0, 1, 1, '0, '0, 1, 0, 3'd3);
        step(1, 0, 0, '0, '0, 0, 0, 3'd3);
        step(0, 0, 0, '0, '0, 0, 0, 3'd3);
        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [N-1:0] q, e;
            q = (($urandom % 6) == 0) ? N'($urandom) : '0;
            e = N'($urandom);
            step(($urandom % 300) == 0, ($urandom % 4) == 0, $urandom % 2, q, e,
                 ($urandom % 3) != 0, ($urandom % 20) == 0, SW'($urandom));
        end
        summary();
    end
endmodule